// File: doc/BRIEF.md
# Serial Management Slave with Control, Status and Event Registers

This block is the management end of a physical-layer transceiver. It runs from the management clock, watches the serial data line for frames from a station manager, and answers reads or takes writes when the frame carries its own PHY address. That address is taken from strap inputs while the hardware reset is held. The block drives the shared data line only during a read. It does so through a separate output value and an output enable, so the pad and its pull-up stay outside.

Behind the frame decoder sits a small register file. It holds a control word, a status word and an event word. The status word mixes capability inputs with a writable flag that lets frames start without a preamble. The event word holds sticky copies of event inputs, in two groups. A latch-high bit keeps a 1 once it has seen one. A latch-low bit keeps a 0 once it has seen one. Reading the event word hands the captured values to the station and then reloads each bit from the live input.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: The two bits after the start delimiter `01` are the opcode. `10` reads and `01` writes. A frame with opcode `00` or `11` never drives the line and changes no register.
- R2: On a read, the line is released for the first turnaround bit and driven to 0 for the second. The 16 data bits follow, most significant first. The line is released again in the bit time after the last data bit.
- R3: On a write, the block does not drive during turnaround. The 16 data bits are taken most significant first into the addressed register.
- R4: The PHY address field, 5 bits after the opcode, is compared with the address latched from `strap_addr` during hardware reset. A mismatching frame is followed to its end with the output enable held low, and its write is dropped. The latched address does not change after reset, including across a software reset.
- R5: Control bit 10 (isolate) resets to 1 exactly when the latched address is 00000. All other control bits reset to 0.
- R6: With the preamble-free flag clear, a start delimiter is accepted only after at least 32 consecutive 1s have been sampled on the line. With 31 or fewer, the frame is ignored.
- R7: Status register (address 1) bit 6 is the preamble-free flag. It is writable and resets to 0. While it is 1, a frame needs no preamble.
- R8: Event register (address 18) bits 3:0 are latch-high. A 1 on an `evt_hi` input sets its bit until the register is read. The read reports the captured value, and the bit then reloads from the current input.
- R9: Event register bits 11:8 are latch-low. A 0 on an `evt_lo` input clears its bit until the register is read. The read reports the captured value, and the bit then reloads from the current input.
- R10: Writing 1 to control bit 15 returns the control, status flag and event bits to their reset values. Bit 15 clears itself one cycle later.
- R11: Control bits 14:0 are read/write. Status bits 15:11 show `caps` and are read-only. Every other status bit reads 0. Register addresses other than 0, 1 and 18 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; every sample and every output change happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low hardware reset; the strap address is latched while it is low |
| strap_addr | input | 5 | PHY address straps |
| caps | input | CAP_W | Capability bits shown in status bits 15:11 |
| evt_hi | input | LH_W | Event inputs for the latch-high bits |
| evt_lo | input | LL_W | Condition inputs for the latch-low bits |
| mdio_in | input | 1 | Level sampled from the management data line |
| mdio_out | output | 1 | Value driven onto the data line while enabled |
| mdio_oe | output | 1 | Output enable of the data line driver |

## Verification
The outputs are registered. If the last register-address bit is sampled at edge E0, the line stays released until E1. The enable rises with a 0 at E1, and data bit 15-k appears at edge E2+k. The release follows at E18, one edge after bit 0. The bench drives each station bit and reads the line at the falling edge inside the same bit slot. Each observation therefore sees the value registered at the rising edge that opened the slot. Event captures and reloads take effect at E2, so an event between frames is always visible to the next read. Preamble counting includes the single idle 1 the bench leaves after every frame, which makes 30 and 31 preamble bits the two sides of the acceptance boundary.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 5;
    localparam int OPC_W    = 2;
    localparam int HDR_BITS = OPC_W + 2 * ADDR_W;

    localparam logic [OPC_W-1:0] OPC_READ  = 2'b10;
    localparam logic [OPC_W-1:0] OPC_WRITE = 2'b01;

    localparam logic [ADDR_W-1:0] REG_CTRL = 5'd0;
    localparam logic [ADDR_W-1:0] REG_STAT = 5'd1;

    localparam int CTRL_SRST_BIT = 15;
    localparam int CTRL_ISO_BIT  = 10;
    localparam int STAT_PSUP_BIT = 6;
    localparam int EVT_LL_LSB    = 8;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_SOF,
        ST_HDR,
        ST_TURN,
        ST_DATA
    } frame_st_e;

    typedef enum logic [1:0] {
        XF_SKIP,
        XF_RD,
        XF_WR
    } xfer_e;

endpackage

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdio_in,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic              psupp,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_req,
    output logic              wr_req,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              mdio_out,
    output logic              mdio_oe,
    output xfer_e             xfer_kind
);

    localparam int PRE_W = $clog2(PRE_LEN + 1);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [PRE_W-1:0] PRE_FULL  = PRE_W'(PRE_LEN);
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        frame_st_e         st;
        xfer_e             xf;
        logic [CNT_W-1:0]  cnt;
        logic [PRE_W-1:0]  ones;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] tx;
        logic [ADDR_W-1:0] regad;
        logic              oe;
        logic              drv;
    } fsm_t;

    fsm_t q, d;
    logic [HDR_BITS-1:0] hdr;
    logic [OPC_W-1:0]    hdr_op;
    logic [ADDR_W-1:0]   hdr_phy;

    always_comb begin
        d       = q;
        rd_req  = 1'b0;
        wr_req  = 1'b0;
        hdr     = {q.sh[HDR_BITS-2:0], mdio_in};
        hdr_op  = hdr[HDR_BITS-1 -: OPC_W];
        hdr_phy = hdr[2*ADDR_W-1:ADDR_W];

        case (q.st)
            ST_HUNT: begin
                if (mdio_in) begin
                    if (q.ones != PRE_FULL) d.ones = q.ones + 1'b1;
                end else begin
                    if (psupp || q.ones == PRE_FULL) d.st = ST_SOF;
                    d.ones = '0;
                end
            end
            ST_SOF: begin
                d.cnt = '0;
                d.st  = mdio_in ? ST_HDR : ST_HUNT;
            end
            ST_HDR: begin
                d.sh  = {q.sh[DATA_W-2:0], mdio_in};
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == HDR_LAST) begin
                    d.st    = ST_TURN;
                    d.cnt   = '0;
                    d.regad = hdr[ADDR_W-1:0];
                    if (hdr_phy != phy_addr)      d.xf = XF_SKIP;
                    else if (hdr_op == OPC_READ)  d.xf = XF_RD;
                    else if (hdr_op == OPC_WRITE) d.xf = XF_WR;
                    else                          d.xf = XF_SKIP;
                end
            end
            ST_TURN: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == '0) begin
                    if (q.xf == XF_RD) begin
                        d.oe  = 1'b1;
                        d.drv = 1'b0;
                    end
                end else begin
                    d.st  = ST_DATA;
                    d.cnt = '0;
                    if (q.xf == XF_RD) begin
                        rd_req = 1'b1;
                        d.drv  = rd_data[DATA_W-1];
                        d.tx   = {rd_data[DATA_W-2:0], 1'b0};
                    end
                end
            end
            ST_DATA: begin
                d.sh  = {q.sh[DATA_W-2:0], mdio_in};
                d.cnt = q.cnt + 1'b1;
                if (q.xf == XF_RD) begin
                    d.drv = q.tx[DATA_W-1];
                    d.tx  = {q.tx[DATA_W-2:0], 1'b0};
                end
                if (q.cnt == DATA_LAST) begin
                    d.st   = ST_HUNT;
                    d.oe   = 1'b0;
                    d.drv  = 1'b0;
                    d.ones = '0;
                    d.xf   = XF_SKIP;
                    if (q.xf == XF_WR) wr_req = 1'b1;
                end
            end
            default: d.st = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign reg_addr  = q.regad;
    assign wr_data   = {q.sh[DATA_W-2:0], mdio_in};
    assign mdio_out  = q.drv;
    assign mdio_oe   = q.oe;
    assign xfer_kind = q.xf;

endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
    import mdio_mgmt_pkg::*;
#(
    parameter int                CAP_W   = 5,
    parameter int                LH_W    = 4,
    parameter int                LL_W    = 4,
    parameter logic [ADDR_W-1:0] EVT_REG = 5'd18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic [CAP_W-1:0]  caps,
    input  logic [LH_W-1:0]   evt_hi,
    input  logic [LL_W-1:0]   evt_lo,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] phy_addr,
    output logic              psupp,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              srst_pend,
    output logic [LH_W-1:0]   lh_q
);

    typedef struct packed {
        logic [ADDR_W-1:0] phy;
        logic [DATA_W-1:0] ctrl;
        logic              psupp;
        logic [LH_W-1:0]   lh;
        logic [LL_W-1:0]   ll;
        logic              srst;
    } regs_t;

    regs_t q, d, rst_val;
    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] evt_word;

    function automatic logic [DATA_W-1:0] ctrl_default(input logic [ADDR_W-1:0] a);
        logic [DATA_W-1:0] v;
        v = '0;
        v[CTRL_ISO_BIT] = (a == '0);
        return v;
    endfunction

    always_comb begin
        rst_val      = '0;
        rst_val.phy  = strap_addr;
        rst_val.ctrl = ctrl_default(strap_addr);
        rst_val.ll   = '1;
    end

    always_comb begin
        d      = q;
        d.srst = 1'b0;
        d.lh   = q.lh | evt_hi;
        d.ll   = q.ll & evt_lo;
        if (rd_req && reg_addr == EVT_REG) begin
            d.lh = evt_hi;
            d.ll = evt_lo;
        end
        if (wr_req) begin
            if (reg_addr == REG_CTRL) begin
                d.ctrl = wr_data;
                d.srst = wr_data[CTRL_SRST_BIT];
            end else if (reg_addr == REG_STAT) begin
                d.psupp = wr_data[STAT_PSUP_BIT];
            end
        end
        if (q.srst) begin
            d.ctrl  = ctrl_default(q.phy);
            d.psupp = 1'b0;
            d.lh    = '0;
            d.ll    = '1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= rst_val;
        else        q <= d;
    end

    always_comb begin
        status_word = '0;
        status_word[DATA_W-1 -: CAP_W] = caps;
        status_word[STAT_PSUP_BIT]     = q.psupp;
        evt_word = '0;
        evt_word[LH_W-1:0]          = q.lh;
        evt_word[EVT_LL_LSB +: LL_W] = q.ll;
        if (reg_addr == REG_CTRL)      rd_data = q.ctrl;
        else if (reg_addr == REG_STAT) rd_data = status_word;
        else if (reg_addr == EVT_REG)  rd_data = evt_word;
        else                           rd_data = '0;
    end

    assign phy_addr  = q.phy;
    assign psupp     = q.psupp;
    assign ctrl_q    = q.ctrl;
    assign srst_pend = q.srst;
    assign lh_q      = q.lh;

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
    import mdio_mgmt_pkg::*;
#(
    parameter int                PRE_LEN = 32,
    parameter int                CAP_W   = 5,
    parameter int                LH_W    = 4,
    parameter int                LL_W    = 4,
    parameter logic [ADDR_W-1:0] EVT_REG = 5'd18
) (
    input  logic             mdc,
    input  logic             rst_n,
    input  logic [4:0]       strap_addr,
    input  logic [CAP_W-1:0] caps,
    input  logic [LH_W-1:0]  evt_hi,
    input  logic [LL_W-1:0]  evt_lo,
    input  logic             mdio_in,
    output logic             mdio_out,
    output logic             mdio_oe
);

    logic              rd_req;
    logic              wr_req;
    logic [ADDR_W-1:0] reg_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic [ADDR_W-1:0] phy_addr;
    logic              psupp;
    logic [DATA_W-1:0] ctrl_q;
    logic              srst_pend;
    logic [LH_W-1:0]   lh_q;
    xfer_e             xfer_kind;

    mdio_frame_fsm #(
        .PRE_LEN(PRE_LEN)
    ) i_frame (
        .clk      (mdc),
        .rst_n    (rst_n),
        .mdio_in  (mdio_in),
        .phy_addr (phy_addr),
        .psupp    (psupp),
        .rd_data  (rd_data),
        .rd_req   (rd_req),
        .wr_req   (wr_req),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe),
        .xfer_kind(xfer_kind)
    );

    mdio_regfile #(
        .CAP_W  (CAP_W),
        .LH_W   (LH_W),
        .LL_W   (LL_W),
        .EVT_REG(EVT_REG)
    ) i_regs (
        .clk       (mdc),
        .rst_n     (rst_n),
        .strap_addr(strap_addr),
        .caps      (caps),
        .evt_hi    (evt_hi),
        .evt_lo    (evt_lo),
        .rd_req    (rd_req),
        .wr_req    (wr_req),
        .reg_addr  (reg_addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .phy_addr  (phy_addr),
        .psupp     (psupp),
        .ctrl_q    (ctrl_q),
        .srst_pend (srst_pend),
        .lh_q      (lh_q)
    );

endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker
    import mdio_mgmt_pkg::*;
#(
    parameter int LH_W = 4
) (
    input logic              mdc,
    input logic              rst_n,
    input logic              mdio_oe,
    input logic              mdio_out,
    input xfer_e             xfer_kind,
    input logic [ADDR_W-1:0] phy_addr,
    input logic              rd_req,
    input logic              srst_pend,
    input logic [DATA_W-1:0] ctrl_q,
    input logic [LH_W-1:0]   evt_hi,
    input logic [LH_W-1:0]   lh_q
);

    // R2: the first driven turnaround bit is a 0
    p_turn_zero_r2: assert property (@(posedge mdc) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_out);

    // R4 and R1: the line is only driven inside an accepted read
    p_drive_only_read_r4: assert property (@(posedge mdc) disable iff (!rst_n)
        mdio_oe |-> (xfer_kind == XF_RD));

    // R4: the strapped address holds after reset
    p_addr_hold_r4: assert property (@(posedge mdc) disable iff (!rst_n)
        $stable(phy_addr));

    // R10: the reset bit clears one cycle after the software reset starts
    p_srst_clear_r10: assert property (@(posedge mdc) disable iff (!rst_n)
        srst_pend |=> (!srst_pend && !ctrl_q[CTRL_SRST_BIT]));

    // R8: a seen event stays captured unless a read or a software reset intervenes
    p_latch_high_r8: assert property (@(posedge mdc) disable iff (!rst_n)
        (!rd_req && !srst_pend) |=> ((lh_q & $past(evt_hi)) == $past(evt_hi)));

endmodule

bind mdio_mgmt_slave mdio_mgmt_checker #(.LH_W(LH_W)) i_mdio_mgmt_checker (
    .mdc      (mdc),
    .rst_n    (rst_n),
    .mdio_oe  (mdio_oe),
    .mdio_out (mdio_out),
    .xfer_kind(xfer_kind),
    .phy_addr (phy_addr),
    .rd_req   (rd_req),
    .srst_pend(srst_pend),
    .ctrl_q   (ctrl_q),
    .evt_hi   (evt_hi),
    .lh_q     (lh_q)
);

// File: tb/test_mdio_mgmt_slave.sv
module test_mdio_mgmt_slave;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] strap = 5'd0;
    logic [4:0] caps = 5'b10110;
    logic [3:0] evt_hi = 4'h0;
    logic [3:0] evt_lo = 4'hF;
    logic       drv = 1'b1;
    logic       mdio_out;
    logic       mdio_oe;
    wire        line = mdio_oe ? mdio_out : drv;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [4:0] my_phy = 5'd0;
    logic [15:0] exp_ctrl;
    logic [15:0] rdv;
    bit drove, resp;

    localparam logic [15:0] STAT_BASE = {5'b10110, 11'b0};

    always #5 clk = ~clk;

    mdio_mgmt_slave i_mdio_mgmt_slave (
        .mdc       (clk),
        .rst_n     (rst_n),
        .strap_addr(strap),
        .caps      (caps),
        .evt_hi    (evt_hi),
        .evt_lo    (evt_lo),
        .mdio_in   (line),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // One frame; drove = line driven anywhere, resp = read turnaround and release correct
    task automatic frame(input int pre, input logic [1:0] op, input logic [4:0] phy,
                         input logic [4:0] ra, input logic [15:0] wd,
                         output logic [15:0] rd, output bit drv_any, output bit ok);
        logic [13:0] hdr;
        hdr = {2'b01, op, phy, ra};
        rd = '0; drv_any = 0; ok = 1;
        for (int i = 0; i < pre; i++) begin
            @(negedge clk); if (mdio_oe) drv_any = 1; drv = 1'b1;
        end
        for (int i = 13; i >= 0; i--) begin
            @(negedge clk); if (mdio_oe) drv_any = 1; drv = hdr[i];
        end
        @(negedge clk); if (mdio_oe) begin drv_any = 1; ok = 0; end drv = 1'b1;
        @(negedge clk); if (mdio_oe) drv_any = 1;
        if (!(mdio_oe && !mdio_out)) ok = 0;
        drv = (op == 2'b01) ? 1'b0 : 1'b1;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk); if (mdio_oe) drv_any = 1; else ok = 0;
            rd[15-k] = line; drv = wd[15-k];
        end
        @(negedge clk); if (mdio_oe) begin drv_any = 1; ok = 0; end drv = 1'b1;
    endtask

    task automatic do_rd(input int pre, input logic [4:0] phy, input logic [4:0] ra,
                         output logic [15:0] v, output bit d, output bit r);
        frame(pre, 2'b10, phy, ra, 16'h0, v, d, r);
    endtask

    task automatic do_wr(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                         input logic [15:0] wd, output bit d);
        logic [15:0] v; bit r;
        frame(32, op, phy, ra, wd, v, d, r);
    endtask

    task automatic hw_reset(input logic [4:0] s);
        strap = s; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #1500000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R5 with address 0
        hw_reset(5'd0);
        chk("R2 reset oe", mdio_oe, 0);
        do_rd(32, 5'd0, 5'd0, rdv, drove, resp);
        chk("R5 isolate default addr0", rdv, 16'h0400);
        chk("R2 read turnaround/release", resp, 1);

        // R5 with address 5
        hw_reset(5'd5);
        my_phy = 5'd5;
        do_rd(32, my_phy, 5'd0, rdv, drove, resp);
        chk("R5 ctrl default addr5", rdv, 16'h0000);

        // R4 address sweep
        for (int a = 0; a < 32; a++) begin
            do_rd(32, 5'(a), 5'd0, rdv, drove, resp);
            chk("R4 drive iff match", drove, (a == 5));
            if (a == 5) chk("R2 match response", resp, 1);
        end

        // R3 writes and read-back
        do_wr(2'b01, my_phy, 5'd0, 16'h1234, drove);
        chk("R3 write not driven", drove, 0);
        exp_ctrl = 16'h1234;
        do_rd(32, my_phy, 5'd0, rdv, drove, resp);
        chk("R3 ctrl readback", rdv, exp_ctrl);
        do_wr(2'b01, 5'd6, 5'd0, 16'h0F0F, drove);
        do_rd(32, my_phy, 5'd0, rdv, drove, resp);
        chk("R4 mismatched write dropped", rdv, exp_ctrl);
        do_wr(2'b00, my_phy, 5'd0, 16'h5555, drove);
        chk("R1 opcode 00 silent", drove, 0);
        do_wr(2'b11, my_phy, 5'd0, 16'h5555, drove);
        chk("R1 opcode 11 silent", drove, 0);
        frame(32, 2'b11, my_phy, 5'd0, 16'h0, rdv, drove, resp);
        chk("R1 opcode 11 read-like silent", drove, 0);
        do_rd(32, my_phy, 5'd0, rdv, drove, resp);
        chk("R1 bad opcodes left ctrl", rdv, exp_ctrl);

        // R11 register map sweep
        for (int r = 0; r < 32; r++) begin
            logic [15:0] e;
            e = (r == 0) ? exp_ctrl : (r == 1) ? STAT_BASE : (r == 18) ? 16'h0F00 : 16'h0;
            do_rd(32, my_phy, 5'(r), rdv, drove, resp);
            chk("R11 register map", rdv, e);
        end
        do_wr(2'b01, my_phy, 5'd1, 16'hFFFF, drove);
        do_rd(32, my_phy, 5'd1, rdv, drove, resp);
        chk("R11 status read-only bits, R7 flag set", rdv, STAT_BASE | 16'h0040);
        do_wr(2'b01, my_phy, 5'd1, 16'h0000, drove);
        do_rd(32, my_phy, 5'd1, rdv, drove, resp);
        chk("R7 flag cleared", rdv, STAT_BASE);

        // R6 preamble boundary (one idle 1 precedes every frame)
        do_rd(30, my_phy, 5'd0, rdv, drove, resp);
        chk("R6 31 ones ignored", drove, 0);
        do_rd(32, my_phy, 5'd0, rdv, drove, resp);
        chk("R6 full preamble", rdv, exp_ctrl);
        do_rd(31, my_phy, 5'd0, rdv, drove, resp);
        chk("R6 32 ones accepted", {resp, rdv}, {1'b1, exp_ctrl});

        // R7 preamble-free mode
        do_wr(2'b01, my_phy, 5'd1, 16'h0040, drove);
        do_rd(0, my_phy, 5'd0, rdv, drove, resp);
        chk("R7 no preamble accepted", {resp, rdv}, {1'b1, exp_ctrl});

        // R8 latch-high
        @(negedge clk); evt_hi = 4'b0101;
        @(negedge clk); evt_hi = 4'b0000;
        do_rd(0, my_phy, 5'd18, rdv, drove, resp);
        chk("R8 pulse captured", rdv, 16'h0F05);
        do_rd(0, my_phy, 5'd18, rdv, drove, resp);
        chk("R8 cleared after read", rdv, 16'h0F00);
        @(negedge clk); evt_hi = 4'b1000;
        do_rd(0, my_phy, 5'd18, rdv, drove, resp);
        chk("R8 held event", rdv, 16'h0F08);
        evt_hi = 4'b0000;
        do_rd(0, my_phy, 5'd18, rdv, drove, resp);
        chk("R8 reload from live input", rdv, 16'h0F08);
        do_rd(0, my_phy, 5'd18, rdv, drove, resp);
        chk("R8 reload cleared", rdv, 16'h0F00);

        // R9 latch-low
        @(negedge clk); evt_lo = 4'b1101;
        @(negedge clk); evt_lo = 4'b1111;
        do_rd(0, my_phy, 5'd18, rdv, drove, resp);
        chk("R9 low pulse captured", rdv, 16'h0D00);
        do_rd(0, my_phy, 5'd18, rdv, drove, resp);
        chk("R9 reload after read", rdv, 16'h0F00);

        // R10 software reset
        @(negedge clk); evt_hi = 4'b0010;
        @(negedge clk); evt_hi = 4'b0000;
        do_wr(2'b01, my_phy, 5'd0, 16'h8123, drove);
        do_rd(32, my_phy, 5'd0, rdv, drove, resp);
        chk("R10 ctrl default, self-clear", {resp, rdv}, {1'b1, 16'h0000});
        do_rd(32, my_phy, 5'd1, rdv, drove, resp);
        chk("R10 status flag cleared", rdv, STAT_BASE);
        do_rd(32, my_phy, 5'd18, rdv, drove, resp);
        chk("R10 events cleared", rdv, 16'h0F00);
        do_rd(0, my_phy, 5'd0, rdv, drove, resp);
        chk("R10 R7 no-preamble refused after reset", drove, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule